// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Expander

This block turns a one-bit serial stream into a parallel output word, for example the drive pattern for a row of indicator lamps. Each accepted bit is pushed into an internal shift stage at the least significant end. The existing contents move one place toward the top, so after WIDTH accepted bits the first bit sent sits in the most significant position.

The visible outputs come from a separate holding register. That register changes only when a latch strobe is pulsed, and it then takes the whole assembled word in one clock. A partially filled pattern never reaches the outputs. The top bit of the shift stage also leaves the block as a serial cascade output, so several units can be chained to form a wider word.

The serial input is a valid/ready stream. A bit transfers on every clock where `in_valid` and `in_ready` are both high. The block never applies back-pressure, so `in_ready` stays high and a producer may present one bit per clock. The latch strobe and the synchronous reset are plain control pins.

Top module: `serpar_expander`

## Requirements
- R1: When `rst` is high at a rising clock edge, both the shift stage and the holding register become all zero, so `par_out` and `cascade_out` read 0 after that edge.
- R2: On an edge where `in_valid` and `in_ready` are both high, the shift stage becomes `{old[WIDTH-2:0], in_data}`. After WIDTH such transfers, the first bit sent occupies bit WIDTH-1.
- R3: On an edge where `latch` is low, `par_out` keeps its value, whatever happens on the serial input.
- R4: On an edge where `latch` is high, `par_out` takes the full shift-stage contents, so all output bits change together one cycle after the strobe.
- R5: When a transfer and `latch` occur on the same edge, `par_out` receives the shift-stage value from before that edge's shift, and the new bit still enters the shift stage.
- R6: `cascade_out` always equals bit WIDTH-1 of the shift stage. It therefore presents each bit WIDTH transfers after that bit entered.
- R7: On an edge with no transfer (`in_valid` low), the shift stage keeps its contents.
- R8: `in_ready` is high in every cycle, including during reset; the block never back-pressures the stream.
- R9: Rules R1 to R7 hold for any WIDTH of 2 or more, not only the default of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Serial bit is offered this cycle |
| in_data | input | 1 | Serial bit value |
| in_ready | output | 1 | Block accepts a bit this cycle (always high) |
| latch | input | 1 | Copy the shift stage to the outputs on this edge |
| par_out | output | WIDTH | Latched parallel output word |
| cascade_out | output | 1 | Top bit of the shift stage, for chaining |

## Verification
The two functions that can fall on the same edge are a serial transfer and the latch strobe. The question on that edge is whether the outputs see the word from before the shift or from after it. The bench drives such edges on purpose: once directly after a full word has been loaded, and many more times through random stimulus where `in_valid` and `latch` are drawn independently. Each edge is judged against a bench model that updates the holding value from the old shift value before it applies the shift. The same stimulus also drives a second instance with a different width.

// File: rtl/serpar_pkg.sv
package serpar_pkg;

  // Combined action for one clock edge.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_SHIFT = 2'b01,
    OP_LATCH = 2'b10,
    OP_BOTH  = 2'b11
  } serpar_op_e;

  function automatic serpar_op_e serpar_decode(input logic take_bit, input logic strobe);
    return serpar_op_e'({strobe, take_bit});
  endfunction

endpackage

// File: rtl/serpar_shift_stage.sv
module serpar_shift_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)           q_r <= '0;
    else if (shift_en) q_r <= {q_r[WIDTH-2:0], din};
  end

  assign q = q_r;

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q)); // R7

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> q[0] == $past(din)); // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0])); // R2

endmodule

// File: rtl/serpar_hold_reg.sv
module serpar_hold_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)       q_r <= '0;
    else if (load) q_r <= d;
  end

  assign q = q_r;

  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R3

endmodule

// File: rtl/serpar_expander.sv
module serpar_expander
  import serpar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_data,
  output logic             in_ready,
  input  logic             latch,
  output logic [WIDTH-1:0] par_out,
  output logic             cascade_out
);

  localparam int MSB = WIDTH - 1;

  serpar_op_e       op;
  logic             do_shift;
  logic             do_load;
  logic [WIDTH-1:0] stage_q;

  assign in_ready = 1'b1;
  assign op       = serpar_decode(in_valid && in_ready, latch);
  assign do_shift = (op == OP_SHIFT) || (op == OP_BOTH);
  assign do_load  = (op == OP_LATCH) || (op == OP_BOTH);

  serpar_shift_stage #(.WIDTH(WIDTH)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .shift_en (do_shift),
    .din      (in_data),
    .q        (stage_q)
  );

  serpar_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (do_load),
    .d    (stage_q),
    .q    (par_out)
  );

  assign cascade_out = stage_q[MSB];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (par_out == '0) && (stage_q == '0)); // R1

  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
    latch |=> par_out == $past(stage_q)); // R4

  AST_BOTH_OLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (latch && in_valid) |=> (par_out == $past(stage_q)) && (stage_q[0] == $past(in_data))); // R5

  AST_CASCADE_LAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> cascade_out == $past(stage_q[MSB-1])); // R6

endmodule

// File: tb/serpar_expander_test.sv
`timescale 1ns/1ps
module serpar_expander_test;

  localparam int WA = 8;
  localparam int WB = 5;

  logic clk = 1'b0;
  logic rst, in_valid, in_data, latch;
  logic ready_a, ready_b, casc_a, casc_b;
  logic [WA-1:0] par_a;
  logic [WB-1:0] par_b;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] sh_a, hd_a, sh_b, hd_b;

  always #2.5 clk = ~clk;

  serpar_expander #(.WIDTH(WA)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(ready_a),
    .latch(latch), .par_out(par_a), .cascade_out(casc_a));

  serpar_expander #(.WIDTH(WB)) uut_w (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(ready_b),
    .latch(latch), .par_out(par_b), .cascade_out(casc_b));

  function automatic logic [15:0] mask_of(input int w);
    return (16'h1 << w) - 16'h1;
  endfunction

  function automatic logic [15:0] next_stage(input logic [15:0] s, input logic b, input int w);
    return ((s << 1) | {15'b0, b}) & mask_of(w);
  endfunction

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Applies one edge of stimulus; starts and ends at a falling edge.
  task automatic step(input logic r, input logic v, input logic d, input logic l, input string req);
    rst = r; in_valid = v; in_data = d; latch = l;
    @(posedge clk);
    if (r) begin
      sh_a = 0; hd_a = 0; sh_b = 0; hd_b = 0;
    end else begin
      if (l) begin hd_a = sh_a; hd_b = sh_b; end
      if (v) begin sh_a = next_stage(sh_a, d, WA); sh_b = next_stage(sh_b, d, WB); end
    end
    @(negedge clk);
    check(par_a == hd_a[WA-1:0], req, {8'b0, par_a}, hd_a);
    check(casc_a == sh_a[WA-1], "R6", {15'b0, casc_a}, {15'b0, sh_a[WA-1]});
    check(par_b == hd_b[WB-1:0], "R9", {11'b0, par_b}, hd_b);
    check(casc_b == sh_b[WB-1], "R9", {15'b0, casc_b}, {15'b0, sh_b[WB-1]});
    check(ready_a && ready_b, "R8", {15'b0, ready_a}, 16'h1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat;
    void'($urandom(32'h5EED_0042));
    rst = 1; in_valid = 0; in_data = 0; latch = 0;
    sh_a = 16'hx; hd_a = 16'hx; sh_b = 16'hx; hd_b = 16'hx;
    @(negedge clk);
    step(1, 1, 1, 1, "R1");
    check(par_a == '0 && casc_a == 1'b0, "R1", {8'b0, par_a}, 16'h0);

    // R2 / R3: load a full word, outputs must stay at the old pattern.
    pat = 8'b1011_0010;
    for (int i = WA - 1; i >= 0; i--) step(0, 1, pat[i], 0, "R3");
    check(casc_a == pat[7], "R6", {15'b0, casc_a}, {15'b0, pat[7]});
    step(0, 0, 0, 1, "R4");
    check(par_a == pat, "R2", {8'b0, par_a}, {8'b0, pat});

    // R7: idle edges keep the stage; a later latch shows the same word.
    step(0, 0, 1, 0, "R7");
    step(0, 0, 0, 1, "R7");
    check(par_a == pat, "R7", {8'b0, par_a}, {8'b0, pat});

    // R5: shift and latch on the same edge.
    step(0, 1, 1, 1, "R5");
    check(par_a == pat, "R5", {8'b0, par_a}, {8'b0, pat});
    step(0, 0, 0, 1, "R5");
    check(par_a == {pat[6:0], 1'b1}, "R5", {8'b0, par_a}, {8'b0, pat[6:0], 1'b1});

    // Random mix of shifts, latches, idles and occasional reset.
    for (int n = 0; n < 3000; n++) begin
      logic r, v, d, l;
      r = ($urandom_range(0, 199) == 0);
      v = ($urandom_range(0, 3) != 0);
      d = $urandom_range(0, 1);
      l = ($urandom_range(0, 5) == 0);
      step(r, v, d, l, l ? "R4" : "R3");
    end

    step(1, 0, 0, 0, "R1");
    check(par_b == '0 && casc_b == 1'b0, "R9", {11'b0, par_b}, 16'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule